// File: doc/BRIEF.md
# CAN Module Sleep and Wakeup Controller

This block decides when the clocks of a CAN protocol module may be switched off while the CPU sleeps, and when they must come back. It watches a sleep-enable configuration bit, a bus-activity flag, the module's pending interrupt lines and the CPU's idle and power-down requests. It drives a sleep-ok status bit, an active-low module idle signal that gates the module clocks, a power-down hold flag and a CPU wake request.

In idle, the module keeps running unless software has set the sleep-enable bit. When gating is allowed and has lasted through a short qualification window, the module is stopped. A level change on the raw CAN receive line is then caught against a stored reference, passed through a synchronizer and used to restart the module clocks. This restart sends no wake request to the CPU. The CPU is woken only when a module interrupt becomes pending (for example message complete) or a system interrupt arrives. In power-down, the same receive-line event starts a fixed delay, and the module runs again only when that delay has ended.

All pins are plain control and status levels. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `can_sleep_ctrl`

## Requirements
- R1: In reset and on the cycle after it, mod_idle_n is 1, pwrdn_hold is 0 and cpu_wake is 0.
- R2: sleep_ok is 1 exactly when bus_busy is 0 and no pend_irq bit is set. It follows those inputs in the same cycle.
- R3: While sleep_en is 0, an idle CPU never gates the module: mod_idle_n stays 1 unless power-down is active.
- R4: With cpu_idle, sleep_en and sleep_ok all held, mod_idle_n falls after ENTRY_CYCLES+1 rising edges. If any of the three drops during that window, entry is cancelled and the window restarts from zero.
- R5: mod_idle_n is 0 only while sleep_ok is 1. A rise of bus_busy or of any pend_irq bit raises mod_idle_n in the same cycle and ends the gated state.
- R6: While gated, a change of can_rx raises mod_idle_n on the third rising edge after the change, and it does not assert cpu_wake.
- R7: cpu_wake equals, one clock later, the OR of all pend_irq and sys_irq bits.
- R8: pd_req with sleep_ok set, seen in the running, entering or gated state, sets pwrdn_hold and holds mod_idle_n at 0 from the next edge.
- R9: In power-down, a change of can_rx starts a delay on the third edge after it. pwrdn_hold falls and mod_idle_n rises PD_DELAY edges later.
- R10: can_rx changes during the power-down delay do not alter its length. Each new power-down restarts the delay from zero.
- R11: A gated module is ungated on the next edge when cpu_idle or sleep_en drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_en | input | 1 | Software bit that allows the module to sleep with the CPU |
| cpu_idle | input | 1 | CPU is in idle |
| pd_req | input | 1 | CPU requests power-down (level) |
| bus_busy | input | 1 | A CAN frame is in progress |
| pend_irq | input | N_PEND | Module interrupts pending |
| sys_irq | input | N_SYS | Other enabled system interrupts |
| can_rx | input | 1 | Raw, unsynchronized CAN receive line |
| sleep_ok | output | 1 | Safe-to-sleep status |
| mod_idle_n | output | 1 | Active-low module clock gate |
| pwrdn_hold | output | 1 | Power-down or its exit delay is in force |
| cpu_wake | output | 1 | Wake request to the CPU |

## Verification
sleep_ok and a forced rise of mod_idle_n are combinational, so they are due in the same cycle as the input change. Entry gating is due ENTRY_CYCLES+1 edges after its conditions. cpu_wake is due one edge after an interrupt. A receive-line wake is due three edges after the change, and a power-down exit PD_DELAY edges later still. The bench drives inputs just after the falling edge and runs a behavioural model on the rising edge. It compares every output a few nanoseconds after each falling edge. Its scenario checks wait exactly these edge counts and look one cycle early as well as on time.

// File: rtl/can_slp_pkg.sv
package can_slp_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_ENTER = 3'd1,
    ST_GATED = 3'd2,
    ST_PD    = 3'd3,
    ST_PDDLY = 3'd4
  } slp_state_e;
endpackage

// File: rtl/slp_counter.sv
// Qualification / delay counter: done while the count sits at LIMIT-1.
module slp_counter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr)           cnt_q <= '0;
    else if (en && !done)   cnt_q <= cnt_q + W'(1);
  end

  assign done = (cnt_q == LAST);
endmodule

// File: rtl/slp_rx_capture.sv
// Receive-line wake detector: compares the raw line with the level it had
// when the module was stopped, then resynchronizes the mismatch.
module slp_rx_capture #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic rx_raw,
  output logic wake
);
  logic                   ref_q;
  logic                   hit;
  logic [SYNC_STAGES-1:0] sync_q;

  // Track the line while disarmed; freeze it as the reference once armed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ref_q <= 1'b1;
    else if (!arm) ref_q <= rx_raw;
  end

  assign hit = arm & (rx_raw ^ ref_q);

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sync_q <= '0;
        else if (!arm) sync_q <= '0;
        else           sync_q <= hit;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sync_q <= '0;
        else if (!arm) sync_q <= '0;
        else           sync_q <= {sync_q[SYNC_STAGES-2:0], hit};
      end
    end
  endgenerate

  assign wake = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/can_sleep_ctrl.sv
module can_sleep_ctrl
  import can_slp_pkg::*;
#(
  parameter int unsigned N_PEND       = 5,
  parameter int unsigned N_SYS        = 4,
  parameter int unsigned ENTRY_CYCLES = 4,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned PD_DELAY     = 9892
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_en,
  input  logic              cpu_idle,
  input  logic              pd_req,
  input  logic              bus_busy,
  input  logic [N_PEND-1:0] pend_irq,
  input  logic [N_SYS-1:0]  sys_irq,
  input  logic              can_rx,
  output logic              sleep_ok,
  output logic              mod_idle_n,
  output logic              pwrdn_hold,
  output logic              cpu_wake
);
  slp_state_e st_q, st_d;
  logic       want_gate;
  logic       armed;
  logic       rx_wake;
  logic       entry_done;
  logic       delay_done;
  logic       wake_q;

  // Safe-to-sleep is combinational so a new interrupt cancels at once.
  assign sleep_ok  = !bus_busy && (pend_irq == '0);
  assign want_gate = cpu_idle && sleep_en && sleep_ok;
  assign armed     = (st_q == ST_GATED) || (st_q == ST_PD) || (st_q == ST_PDDLY);

  slp_rx_capture #(.SYNC_STAGES(SYNC_STAGES)) u_rxcap (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (armed),
    .rx_raw (can_rx),
    .wake   (rx_wake)
  );

  slp_counter #(.LIMIT(ENTRY_CYCLES)) u_entry (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q != ST_ENTER),
    .en    (st_q == ST_ENTER),
    .done  (entry_done)
  );

  slp_counter #(.LIMIT(PD_DELAY)) u_pddly (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q != ST_PDDLY),
    .en    (st_q == ST_PDDLY),
    .done  (delay_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN: begin
        if (pd_req && sleep_ok) st_d = ST_PD;
        else if (want_gate)     st_d = ST_ENTER;
      end
      ST_ENTER: begin
        if (pd_req && sleep_ok) st_d = ST_PD;
        else if (!want_gate)    st_d = ST_RUN;
        else if (entry_done)    st_d = ST_GATED;
      end
      ST_GATED: begin
        if (!want_gate || rx_wake) st_d = ST_RUN;
        else if (pd_req)           st_d = ST_PD;
      end
      ST_PD: begin
        if (!sleep_ok)    st_d = ST_RUN;
        else if (rx_wake) st_d = ST_PDDLY;
      end
      ST_PDDLY: begin
        if (delay_done) st_d = ST_RUN;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      wake_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wake_q <= (|pend_irq) || (|sys_irq);
    end
  end

  assign mod_idle_n = !(armed && sleep_ok);
  assign pwrdn_hold = (st_q == ST_PD) || (st_q == ST_PDDLY);
  assign cpu_wake   = wake_q;
endmodule

// File: rtl/can_sleep_ctrl_chk.sv
module can_sleep_ctrl_chk #(
  parameter int unsigned N_PEND = 5,
  parameter int unsigned N_SYS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_en,
  input logic              cpu_idle,
  input logic              pd_req,
  input logic [N_PEND-1:0] pend_irq,
  input logic [N_SYS-1:0]  sys_irq,
  input logic              sleep_ok,
  input logic              mod_idle_n,
  input logic              pwrdn_hold,
  input logic              cpu_wake
);
  assert_no_gate_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_en && $past(!sleep_en) && !pwrdn_hold) |-> mod_idle_n);

  assert_gate_entry_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mod_idle_n) && !pwrdn_hold) |-> $past(cpu_idle && sleep_en && sleep_ok));

  assert_unsafe_ungates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_ok && !pwrdn_hold) |=> mod_idle_n);

  assert_wake_follows_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wake == $past((|pend_irq) || (|sys_irq)));

  assert_pd_entry_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrdn_hold) |-> $past(pd_req && sleep_ok));
endmodule

bind can_sleep_ctrl can_sleep_ctrl_chk #(.N_PEND(N_PEND), .N_SYS(N_SYS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep_en   (sleep_en),
  .cpu_idle   (cpu_idle),
  .pd_req     (pd_req),
  .pend_irq   (pend_irq),
  .sys_irq    (sys_irq),
  .sleep_ok   (sleep_ok),
  .mod_idle_n (mod_idle_n),
  .pwrdn_hold (pwrdn_hold),
  .cpu_wake   (cpu_wake)
);

// File: tb/tb_can_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_can_sleep_ctrl;
  localparam int NP = 5;
  localparam int NS = 4;
  localparam int EC = 4;
  localparam int PDD = 9892;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_en = 0, cpu_idle = 0, pd_req = 0, bus_busy = 0, can_rx = 1;
  logic [NP-1:0] pend_irq = '0;
  logic [NS-1:0] sys_irq = '0;
  logic sleep_ok, mod_idle_n, pwrdn_hold, cpu_wake;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  can_sleep_ctrl #(.N_PEND(NP), .N_SYS(NS), .ENTRY_CYCLES(EC),
                   .SYNC_STAGES(2), .PD_DELAY(PDD)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .cpu_idle(cpu_idle),
    .pd_req(pd_req), .bus_busy(bus_busy), .pend_irq(pend_irq),
    .sys_irq(sys_irq), .can_rx(can_rx), .sleep_ok(sleep_ok),
    .mod_idle_n(mod_idle_n), .pwrdn_hold(pwrdn_hold), .cpu_wake(cpu_wake));

  // Behavioural reference: modes 0 run, 1 qualifying, 2 stopped,
  // 3 power-down, 4 power-down exit delay.
  int m_mode, m_qual, m_dly;
  bit m_ref, m_p0, m_p1, m_wake;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_qual = 0; m_dly = 0;
      m_ref = 1; m_p0 = 0; m_p1 = 0; m_wake = 0;
    end else begin
      bit ok, want, stopped, seen;
      int nxt;
      ok = !bus_busy && (pend_irq == 0);
      want = cpu_idle && sleep_en && ok;
      stopped = (m_mode >= 2);
      seen = m_p1;
      nxt = m_mode;
      if (m_mode == 0) begin
        if (pd_req && ok) nxt = 3; else if (want) begin nxt = 1; m_qual = 0; end
      end else if (m_mode == 1) begin
        if (pd_req && ok) nxt = 3;
        else if (!want) nxt = 0;
        else if (m_qual == EC - 1) nxt = 2;
        else m_qual++;
      end else if (m_mode == 2) begin
        if (!want || seen) nxt = 0; else if (pd_req) nxt = 3;
      end else if (m_mode == 3) begin
        if (!ok) nxt = 0; else if (seen) begin nxt = 4; m_dly = 0; end
      end else begin
        if (m_dly == PDD - 1) nxt = 0; else m_dly++;
      end
      m_p1 = stopped ? m_p0 : 1'b0;
      m_p0 = stopped ? (can_rx != m_ref) : 1'b0;
      if (!stopped) m_ref = can_rx;
      m_wake = (pend_irq != 0) || (sys_irq != 0);
      m_mode = nxt;
    end
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    #5;
    if (!finished) begin
      bit eok, eidle_n;
      eok = !bus_busy && (pend_irq == 0);
      eidle_n = !((m_mode >= 2) && eok);
      chk(sleep_ok == eok, "R2 model sleep_ok", sleep_ok, eok);
      chk(mod_idle_n == eidle_n, "R5 model mod_idle_n", mod_idle_n, eidle_n);
      chk(pwrdn_hold == (m_mode >= 3), "R9 model pwrdn_hold", pwrdn_hold, m_mode >= 3);
      chk(cpu_wake == m_wake, "R7 model cpu_wake", cpu_wake, m_wake);
    end
  end

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
    #6;
  endtask

  task automatic gate_up();
    cpu_idle = 1; sleep_en = 1;
    negs(EC + 1);
  endtask

  task automatic pd_round(input string tag);
    pd_req = 1;
    negs(1);
    chk(pwrdn_hold == 1, "R8 power-down entered", pwrdn_hold, 1);
    chk(mod_idle_n == 0, "R8 module stopped in power-down", mod_idle_n, 0);
    pd_req = 0;
    negs(3);
    can_rx = ~can_rx;
    negs(8);
    can_rx = ~can_rx;          // ignored during delay (R10)
    negs(5);
    can_rx = ~can_rx;
    negs(PDD + 2 - 13);
    chk(pwrdn_hold == 1, {tag, " hold one cycle before end"}, pwrdn_hold, 1);
    chk(mod_idle_n == 0, {tag, " still stopped before end"}, mod_idle_n, 0);
    negs(1);
    chk(pwrdn_hold == 0, {tag, " hold released"}, pwrdn_hold, 0);
    chk(mod_idle_n == 1, {tag, " module running"}, mod_idle_n, 1);
    chk(cpu_wake == 0, "R6 no CPU wake from line", cpu_wake, 0);
  endtask

  initial begin
    negs(3);
    chk(mod_idle_n == 1 && pwrdn_hold == 0 && cpu_wake == 0, "R1 in reset", mod_idle_n, 1);
    rst_n = 1;
    negs(1);
    chk(mod_idle_n == 1 && pwrdn_hold == 0 && cpu_wake == 0, "R1 after reset", mod_idle_n, 1);

    // R2 / R7
    bus_busy = 1; #1;
    chk(sleep_ok == 0, "R2 busy clears sleep_ok", sleep_ok, 0);
    bus_busy = 0; pend_irq = 5'b00100; #1;
    chk(sleep_ok == 0, "R2 pending clears sleep_ok", sleep_ok, 0);
    chk(cpu_wake == 0, "R7 wake not yet", cpu_wake, 0);
    negs(1);
    chk(cpu_wake == 1, "R7 wake one edge later", cpu_wake, 1);
    pend_irq = 0; sys_irq = 4'b1000;
    negs(1);
    chk(cpu_wake == 1, "R7 system irq wakes", cpu_wake, 1);
    sys_irq = 0;
    negs(1);
    chk(cpu_wake == 0, "R7 wake released", cpu_wake, 0);

    // R3
    cpu_idle = 1; sleep_en = 0;
    negs(10);
    chk(mod_idle_n == 1, "R3 disabled sleep keeps module", mod_idle_n, 1);

    // R4 with a cancel
    sleep_en = 1;
    negs(3);
    bus_busy = 1;
    negs(1);
    bus_busy = 0;
    negs(EC);
    chk(mod_idle_n == 1, "R4 cancelled entry restarts", mod_idle_n, 1);
    negs(1);
    chk(mod_idle_n == 0, "R4 gated after restart window", mod_idle_n, 0);

    // R5
    pend_irq = 5'b00001; #1;
    chk(mod_idle_n == 1, "R5 pending ungates same cycle", mod_idle_n, 1);
    negs(1);
    pend_irq = 0; #1;
    chk(mod_idle_n == 1, "R5 gated state left", mod_idle_n, 1);
    negs(EC);
    chk(mod_idle_n == 1, "R4 one edge short", mod_idle_n, 1);
    negs(1);
    chk(mod_idle_n == 0, "R4 gated exactly on time", mod_idle_n, 0);

    // R6
    can_rx = 0;
    negs(2);
    chk(mod_idle_n == 0, "R6 not yet woken", mod_idle_n, 0);
    negs(1);
    chk(mod_idle_n == 1, "R6 line wake", mod_idle_n, 1);
    chk(cpu_wake == 0, "R6 CPU stays asleep", cpu_wake, 0);
    bus_busy = 1;
    negs(20);
    bus_busy = 0; pend_irq = 5'b10000;
    negs(1);
    chk(cpu_wake == 1, "R7 message complete wakes CPU", cpu_wake, 1);
    pend_irq = 0;
    negs(1);

    // R11
    gate_up();
    chk(mod_idle_n == 0, "R4 gated again", mod_idle_n, 0);
    cpu_idle = 0; #1;
    chk(mod_idle_n == 0, "R11 still gated until edge", mod_idle_n, 0);
    negs(1);
    chk(mod_idle_n == 1, "R11 ungated after idle drop", mod_idle_n, 1);
    gate_up();
    sleep_en = 0;
    negs(1);
    chk(mod_idle_n == 1, "R11 ungated after enable drop", mod_idle_n, 1);

    // R8 / R9 / R10: two power-down rounds from run state
    cpu_idle = 0;
    negs(2);
    pd_round("R9 first exit");
    negs(3);
    pd_round("R10 second exit");

    // Power-down left by pending interrupt
    pd_req = 1;
    negs(1);
    pd_req = 0; sys_irq = 4'b0001; pend_irq = 5'b00010;
    negs(1);
    chk(pwrdn_hold == 0, "R5 interrupt ends power-down", pwrdn_hold, 0);
    pend_irq = 0; sys_irq = 0;
    negs(3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 60000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule